// File: doc/BRIEF.md
# UART FIFO control and trigger unit

This block sits between a CPU register port and the receive and transmit paths of a UART. It holds the 8-bit FIFO control word and owns two byte FIFOs, one per direction, each 16 entries deep. The receive shift register hands each finished character in through a load strobe. The CPU pops received bytes and pushes bytes to transmit. The transmit shift register takes bytes from the other FIFO.

From the receive fill level and the programmed threshold, the block raises a receive-data-available interrupt. It also produces a 4-bit interrupt identification code, which is what a CPU read at the control word's address returns. It further produces a data-ready flag, a one-cycle overrun pulse and the selected ready/DMA signalling mode. Line-status conditions come in from outside and outrank the data interrupt. A dropped receive byte counts as one of these conditions.

The control word is write-only. The enable bit gates every other field. The two clear bits act on the cycle of the write and are never stored.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the FIFOs are disabled, both counts are 0, `trig_sel` is 00, `dma_mode` is 0, `rda_irq` and `data_ready` are 0, and `int_id` reads 0001.
- R2: A control write with bit 0 = 0 leaves `trig_sel` unchanged and leaves `dma_mode` at 0, and its bits 1 and 2 clear nothing beyond what R3 causes. Bits 4 and 5 of any control write have no effect.
- R3: A control write whose bit 0 differs from the current `fifo_en` empties both FIFOs. A write that keeps bit 0 equal to `fifo_en`, with bits 1 and 2 at 0, leaves both counts unchanged.
- R4: A control write with bit 0 = 1 and bit 1 = 1 makes `rx_count` 0. The bit is not stored, so a later write with bit 1 = 0 empties nothing.
- R5: A control write with bit 0 = 1 and bit 2 = 1 makes `tx_count` 0 and leaves `rx_count` untouched.
- R6: A control write with bit 0 = 1 stores bit 3 as `dma_mode`. Mode 1 is shown only while the FIFOs are enabled.
- R7: A control write with bit 0 = 1 stores bits 7:6 as `trig_sel`. The codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 bytes.
- R8: With `fifo_en` = 1 and `rx_ie` = 1, `rda_irq` is 1 and `int_id` reads 0100 exactly while `rx_count` is at or above the threshold. Both drop as soon as the count falls below it.
- R9: While `ls_ie` = 1 and either `line_err` or `overrun` is 1, `int_id` reads 0110 whatever the receive level is. With nothing pending it reads 0001.
- R10: `data_ready` rises on the cycle after a character is loaded into the receive FIFO. It falls once the FIFO is empty.
- R11: A character loaded into a full receive FIFO is dropped: the count stays at 16 and `overrun` pulses high for one cycle.
- R12: CPU pops, CPU pushes, receive loads and transmit takes act only while `fifo_en` = 1. Each FIFO returns bytes in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word |
| host_wr | input | 1 | CPU push to the transmit FIFO |
| host_wdata | input | 8 | Byte pushed by the CPU |
| host_rd | input | 1 | CPU pop from the receive FIFO |
| host_rdata | output | 8 | Oldest received byte (show-ahead) |
| rx_load | input | 1 | Receive shift register hands in a character |
| rx_char | input | 8 | Character handed in |
| tx_take | input | 1 | Transmit shift register takes a byte |
| tx_char | output | 8 | Oldest byte waiting to be sent (show-ahead) |
| rx_ie | input | 1 | Receive data interrupt enable |
| ls_ie | input | 1 | Line-status interrupt enable |
| line_err | input | 1 | External line-status condition pending |
| fifo_en | output | 1 | FIFOs enabled |
| dma_mode | output | 1 | Ready/DMA signalling mode (0 or 1) |
| trig_sel | output | 2 | Stored threshold code |
| rx_count | output | 5 | Receive FIFO fill level |
| tx_count | output | 5 | Transmit FIFO fill level |
| data_ready | output | 1 | Receive FIFO holds data |
| rda_irq | output | 1 | Receive data available interrupt |
| int_id | output | 4 | Interrupt identification code |
| overrun | output | 1 | One-cycle pulse after a dropped receive byte |

## Verification
All stored state updates on the clock edge that captures a strobe. Counts, configuration, `data_ready`, `rda_irq` and the `int_id` data code are therefore due one edge after the stimulus. `overrun` is due on the edge after the dropped load, and `int_id` follows `line_err` within the same cycle. The bench drives each strobe on a falling edge and samples on the next falling edge, so it sees exactly one rising edge in between. It checks the combinational priority path a short delay after driving `line_err`. Received and transmitted bytes are compared by monitors at the clock edge of each pop, against queues that the driver tasks fill with the bytes it expects the design to accept.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
   localparam int CTL_W = 8;
   localparam int B_EN    = 0;
   localparam int B_RXCLR = 1;
   localparam int B_TXCLR = 2;
   localparam int B_DMA   = 3;
   localparam int B_TRIG  = 6;

   localparam logic [3:0] ID_NONE = 4'b0001;
   localparam logic [3:0] ID_LINE = 4'b0110;
   localparam logic [3:0] ID_DATA = 4'b0100;

   typedef struct packed {
      logic       en;
      logic       dma;
      logic [1:0] trig;
   } ufc_cfg_t;
endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty,
   output logic             dropped
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ufc_fifo: DEPTH must be at least 2");
      end
      if ((2 ** AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign dropped = push & ~do_push & ~clr;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
   import ufc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output ufc_cfg_t         cfg,
   output logic             rx_clr,
   output logic             tx_clr
);
   ufc_cfg_t cfg_q;
   logic     en_flip, live;
   logic     unused_rsvd;

   assign unused_rsvd = ^wdata[5:4];
   assign live    = wr & wdata[B_EN];
   assign en_flip = wr & (wdata[B_EN] != cfg_q.en);
   assign rx_clr  = en_flip | (live & wdata[B_RXCLR]);
   assign tx_clr  = en_flip | (live & wdata[B_TXCLR]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (wr) cfg_q.en <= wdata[B_EN];
         if (live) begin
            cfg_q.dma  <= wdata[B_DMA];
            cfg_q.trig <= wdata[B_TRIG+1:B_TRIG];
         end
      end
   end

   always_comb begin
      cfg     = cfg_q;
      cfg.dma = cfg_q.dma & cfg_q.en;
   end
endmodule

// File: rtl/ufc_rx_irq.sv
module ufc_rx_irq
   import ufc_pkg::*;
#(
   parameter int CW     = 5,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14
) (
   input  ufc_cfg_t      cfg,
   input  logic          rx_ie,
   input  logic          ls_ie,
   input  logic          line_err,
   input  logic          overrun,
   input  logic [CW-1:0] rx_count,
   output logic          rda_irq,
   output logic [3:0]    int_id,
   output logic          data_ready
);
   logic [CW-1:0] level;
   logic          ls_pend;

   always_comb begin
      unique case (cfg.trig)
         2'b00:   level = CW'(TRIG_A);
         2'b01:   level = CW'(TRIG_B);
         2'b10:   level = CW'(TRIG_C);
         default: level = CW'(TRIG_D);
      endcase
   end

   assign rda_irq    = cfg.en & rx_ie & (rx_count >= level);
   assign ls_pend    = ls_ie & (line_err | overrun);
   assign data_ready = (rx_count != '0);

   always_comb begin
      if (ls_pend)      int_id = ID_LINE;
      else if (rda_irq) int_id = ID_DATA;
      else              int_id = ID_NONE;
   end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
   import ufc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_char,
   input  logic              tx_take,
   output logic [DATA_W-1:0] tx_char,
   input  logic              rx_ie,
   input  logic              ls_ie,
   input  logic              line_err,
   output logic              fifo_en,
   output logic              dma_mode,
   output logic [1:0]        trig_sel,
   output logic [CNT_W-1:0]  rx_count,
   output logic [CNT_W-1:0]  tx_count,
   output logic              data_ready,
   output logic              rda_irq,
   output logic [3:0]        int_id,
   output logic              overrun
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("uart_fifo_ctl: DATA_W must be positive");
      end
      if (!(TRIG_A >= 1 && TRIG_A < TRIG_B && TRIG_B < TRIG_C &&
            TRIG_C < TRIG_D && TRIG_D <= DEPTH)) begin : g_bad_trig
         $error("uart_fifo_ctl: thresholds must rise strictly and fit DEPTH");
      end
   endgenerate

   ufc_cfg_t cfg;
   logic     rx_clr, tx_clr, rx_drop, overrun_q;
   logic     unused_rx_full, unused_rx_empty;
   logic     unused_tx_full, unused_tx_empty, unused_tx_drop;

   ufc_ctl_reg u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wdata  (ctl_wdata),
      .cfg    (cfg),
      .rx_clr (rx_clr),
      .tx_clr (tx_clr)
   );

   ufc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rx_clr),
      .push    (rx_load & cfg.en),
      .pop     (host_rd & cfg.en),
      .din     (rx_char),
      .dout    (host_rdata),
      .count   (rx_count),
      .full    (unused_rx_full),
      .empty   (unused_rx_empty),
      .dropped (rx_drop)
   );

   ufc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tx_clr),
      .push    (host_wr & cfg.en),
      .pop     (tx_take & cfg.en),
      .din     (host_wdata),
      .dout    (tx_char),
      .count   (tx_count),
      .full    (unused_tx_full),
      .empty   (unused_tx_empty),
      .dropped (unused_tx_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overrun_q <= 1'b0;
      else        overrun_q <= rx_drop;
   end

   ufc_rx_irq #(
      .CW(CNT_W), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B),
      .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
   ) u_irq (
      .cfg        (cfg),
      .rx_ie      (rx_ie),
      .ls_ie      (ls_ie),
      .line_err   (line_err),
      .overrun    (overrun_q),
      .rx_count   (rx_count),
      .rda_irq    (rda_irq),
      .int_id     (int_id),
      .data_ready (data_ready)
   );

   assign fifo_en  = cfg.en;
   assign dma_mode = cfg.dma;
   assign trig_sel = cfg.trig;
   assign overrun  = overrun_q;
endmodule

// File: rtl/ufc_checks.sv
module ufc_checks #(
   parameter int DEPTH  = 16,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic [7:0]       ctl_wdata,
   input logic             host_rd,
   input logic             rx_load,
   input logic             ls_ie,
   input logic             line_err,
   input logic             rx_ie,
   input logic             fifo_en,
   input logic             dma_mode,
   input logic [1:0]       trig_sel,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             data_ready,
   input logic             rda_irq,
   input logic [3:0]       int_id,
   input logic             overrun
);
   logic [CNT_W-1:0] lvl;
   logic             unused_rsvd;
   assign unused_rsvd = ^ctl_wdata[5:4];

   always_comb begin
      case (trig_sel)
         2'b00:   lvl = CNT_W'(TRIG_A);
         2'b01:   lvl = CNT_W'(TRIG_B);
         2'b10:   lvl = CNT_W'(TRIG_C);
         default: lvl = CNT_W'(TRIG_D);
      endcase
   end

   assert_unprogrammed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !ctl_wdata[0] |=> $stable(trig_sel) && !dma_mode && !fifo_en);

   assert_flip_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && (ctl_wdata[0] != fifo_en) |=> rx_count == '0 && tx_count == '0);

   assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[0] && ctl_wdata[1] |=> rx_count == '0);

   assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[0] && ctl_wdata[2] |=> tx_count == '0);

   assert_dma_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[0] |=> dma_mode == $past(ctl_wdata[3]));

   assert_trig_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[0] |=> trig_sel == $past(ctl_wdata[7:6]));

   assert_rda_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rda_irq |-> fifo_en && rx_ie && rx_count >= lvl);

   assert_rda_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rda_irq && !(ls_ie && (line_err || overrun)) |-> int_id == 4'b0100);

   assert_line_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ls_ie && line_err |-> int_id == 4'b0110);

   assert_data_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_load && !ctl_wr |=> data_ready);

   assert_overrun_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && rx_load && rx_count == CNT_W'(DEPTH) && !host_rd && !ctl_wr
      |=> overrun && rx_count == CNT_W'(DEPTH));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH) && tx_count <= CNT_W'(DEPTH));

   assert_idle_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> rx_count == '0 && tx_count == '0);
endmodule

bind uart_fifo_ctl ufc_checks #(
   .DEPTH(DEPTH), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_wr     (ctl_wr),
   .ctl_wdata  (ctl_wdata),
   .host_rd    (host_rd),
   .rx_load    (rx_load),
   .ls_ie      (ls_ie),
   .line_err   (line_err),
   .rx_ie      (rx_ie),
   .fifo_en    (fifo_en),
   .dma_mode   (dma_mode),
   .trig_sel   (trig_sel),
   .rx_count   (rx_count),
   .tx_count   (tx_count),
   .data_ready (data_ready),
   .rda_irq    (rda_irq),
   .int_id     (int_id),
   .overrun    (overrun)
);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic       rx_load = 1'b0;
   logic [7:0] rx_char = '0;
   logic       tx_take = 1'b0;
   logic [7:0] tx_char;
   logic       rx_ie = 1'b0;
   logic       ls_ie = 1'b0;
   logic       line_err = 1'b0;
   logic       fifo_en, dma_mode, data_ready, rda_irq, overrun;
   logic [1:0] trig_sel;
   logic [4:0] rx_count, tx_count;
   logic [3:0] int_id;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_rx[$];
   logic [7:0] exp_tx[$];

   always #2.5 clk = ~clk;

   uart_fifo_ctl u_uart_fifo_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .host_rdata(host_rdata), .rx_load(rx_load), .rx_char(rx_char),
      .tx_take(tx_take), .tx_char(tx_char), .rx_ie(rx_ie), .ls_ie(ls_ie),
      .line_err(line_err), .fifo_en(fifo_en), .dma_mode(dma_mode),
      .trig_sel(trig_sel), .rx_count(rx_count), .tx_count(tx_count),
      .data_ready(data_ready), .rda_irq(rda_irq), .int_id(int_id),
      .overrun(overrun)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // monitors: compare popped bytes against the scoreboard queues (R12)
   always @(posedge clk) begin
      if (rst_n && host_rd && fifo_en && exp_rx.size() > 0) begin
         logic [7:0] e;
         e = exp_rx.pop_front();
         chk("R12", "rx byte order", {24'd0, host_rdata}, {24'd0, e});
      end
      if (rst_n && tx_take && fifo_en && exp_tx.size() > 0) begin
         logic [7:0] e;
         e = exp_tx.pop_front();
         chk("R12", "tx byte order", {24'd0, tx_char}, {24'd0, e});
      end
   end

   task automatic ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] b, input bit accept);
      rx_load = 1'b1; rx_char = b;
      if (accept) exp_rx.push_back(b);
      @(negedge clk);
      rx_load = 1'b0;
   endtask

   task automatic host_push(input logic [7:0] b, input bit accept);
      host_wr = 1'b1; host_wdata = b;
      if (accept) exp_tx.push_back(b);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_pop();
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic tx_pop();
      tx_take = 1'b1;
      @(negedge clk);
      tx_take = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "fifo_en", 32'(fifo_en), 0);
      chk("R1", "rx_count", 32'(rx_count), 0);
      chk("R1", "tx_count", 32'(tx_count), 0);
      chk("R1", "trig_sel", 32'(trig_sel), 0);
      chk("R1", "dma_mode", 32'(dma_mode), 0);
      chk("R1", "rda_irq", 32'(rda_irq), 0);
      chk("R1", "data_ready", 32'(data_ready), 0);
      chk("R1", "int_id", 32'(int_id), 4'b0001);

      rx_in(8'h99, 0);
      host_push(8'h98, 0);
      chk("R12", "rx load ignored while disabled", 32'(rx_count), 0);
      chk("R12", "host push ignored while disabled", 32'(tx_count), 0);

      ctl(8'h01);
      chk("R7", "enable with trig 00", 32'({fifo_en, trig_sel}), 3'b100);
      rx_ie = 1'b1;
      ls_ie = 1'b1;
      rx_in(8'hA5, 1);
      chk("R10", "data_ready after load", 32'(data_ready), 1);
      chk("R8", "rda at 1 byte", 32'(rda_irq), 1);
      chk("R8", "int_id data", 32'(int_id), 4'b0100);
      line_err = 1'b1;
      #1;
      chk("R9", "line status outranks data", 32'(int_id), 4'b0110);
      @(negedge clk);
      line_err = 1'b0;
      #1;
      chk("R8", "int_id back to data", 32'(int_id), 4'b0100);
      @(negedge clk);
      host_pop();
      chk("R10", "data_ready after empty", 32'(data_ready), 0);
      chk("R8", "rda falls", 32'(rda_irq), 0);
      chk("R9", "int_id none", 32'(int_id), 4'b0001);

      ctl(8'h41);
      chk("R7", "trig 01", 32'(trig_sel), 1);
      for (int i = 0; i < 3; i++) rx_in(8'h10 + 8'(i), 1);
      chk("R8", "below 4 bytes", 32'(rda_irq), 0);
      rx_in(8'h13, 1);
      chk("R8", "at 4 bytes", 32'(rda_irq), 1);
      host_pop();
      chk("R8", "falls at 3 bytes", 32'(rda_irq), 0);
      chk("R8", "int_id none at 3", 32'(int_id), 4'b0001);

      ctl(8'h71);
      chk("R2", "reserved bits ignore trig", 32'(trig_sel), 1);
      chk("R2", "reserved bits no dma", 32'(dma_mode), 0);
      chk("R3", "same enable keeps rx", 32'(rx_count), 3);

      host_push(8'h11, 1);
      host_push(8'h22, 1);
      host_push(8'h33, 1);
      chk("R12", "tx count 3", 32'(tx_count), 3);
      tx_pop();
      chk("R12", "tx count 2", 32'(tx_count), 2);
      ctl(8'h45);
      exp_tx.delete();
      chk("R5", "tx cleared", 32'(tx_count), 0);
      chk("R5", "rx untouched", 32'(rx_count), 3);
      host_push(8'h44, 1);
      tx_pop();
      chk("R12", "tx empty again", 32'(tx_count), 0);

      ctl(8'h43);
      exp_rx.delete();
      chk("R4", "rx cleared", 32'(rx_count), 0);
      chk("R10", "data_ready after clear", 32'(data_ready), 0);
      rx_in(8'h55, 1);
      ctl(8'h41);
      chk("R4", "clear bit self-clears", 32'(rx_count), 1);

      ctl(8'h49);
      chk("R6", "dma mode 1", 32'(dma_mode), 1);
      ctl(8'h41);
      chk("R6", "dma mode 0", 32'(dma_mode), 0);

      ctl(8'hC1);
      chk("R7", "trig 11", 32'(trig_sel), 3);
      for (int i = 0; i < 12; i++) rx_in(8'h60 + 8'(i), 1);
      chk("R8", "13 bytes below 14", 32'(rda_irq), 0);
      rx_in(8'h6C, 1);
      chk("R8", "14 bytes", 32'(rda_irq), 1);
      rx_in(8'h6D, 1);
      rx_in(8'h6E, 1);
      chk("R11", "full at 16", 32'(rx_count), 16);
      rx_in(8'hEE, 0);
      chk("R11", "dropped keeps 16", 32'(rx_count), 16);
      chk("R11", "overrun pulse", 32'(overrun), 1);
      chk("R9", "overrun gives line code", 32'(int_id), 4'b0110);
      @(negedge clk);
      chk("R11", "overrun one cycle", 32'(overrun), 0);
      for (int i = 0; i < 16; i++) host_pop();
      chk("R12", "rx drained", 32'(rx_count), 0);

      ctl(8'h81);
      for (int i = 0; i < 7; i++) rx_in(8'h30 + 8'(i), 1);
      chk("R7", "7 bytes below 8", 32'(rda_irq), 0);
      rx_in(8'h37, 1);
      chk("R7", "8 bytes", 32'(rda_irq), 1);

      ctl(8'h00);
      exp_rx.delete();
      chk("R3", "disable empties rx", 32'(rx_count), 0);
      chk("R3", "disabled", 32'(fifo_en), 0);
      chk("R8", "no rda disabled", 32'(rda_irq), 0);
      ctl(8'hCE);
      chk("R2", "trig kept when bit0 is 0", 32'(trig_sel), 2);
      chk("R2", "dma kept 0", 32'(dma_mode), 0);
      chk("R2", "still disabled", 32'(fifo_en), 0);

      ctl(8'h01);
      rx_in(8'h77, 1);
      host_push(8'h78, 1);
      ctl(8'h00);
      exp_rx.delete();
      exp_tx.delete();
      chk("R3", "disable empties tx", 32'(tx_count), 0);
      chk("R3", "disable empties rx again", 32'(rx_count), 0);

      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule